// File: doc/BRIEF.md
# Programmable Fill-Level Threshold Flag

This block watches the word count of a 512-word FIFO and raises a single threshold flag whenever the buffer is close to either end: nearly drained or nearly filled. Two 8-bit offsets set the margins. The low offset sets how few words count as "nearly empty". The high offset sets how many free slots remain when the buffer counts as "nearly full". Both offsets start at 64.

Software or board logic can change the offsets once per reset. The window opens after reset and closes when the first data word enters the FIFO. Holding the active-low program strobe for one write-clock edge stores the low 8 data bits into both offsets. Holding it for a second edge replaces only the high offset. Any further edges are ignored. While a programming edge is being accepted, the block drives a write-inhibit output so that the FIFO does not store the data bits as a data word. The storage array and its pointers are outside this block.

Top module: `fifo_level_flag`

## Requirements
- R1: With no programming after reset, both offsets are 64: the flag is high for counts 0..64 and 448..512, and low for 65..447.
- R2: The flag is high exactly when the word count is at most the low offset X, or at least 512 minus the high offset Y.
- R3: While reset is asserted (rst_n low) and right after it is released, the flag is high, whatever the word count.
- R4: On the first rising edge with prog_n low (input ready high, no word yet written), the 8-bit prog_data value is stored into both X and Y.
- R5: If prog_n is still low on the next rising edge, only Y takes the new prog_data value, and X keeps the value from the first edge.
- R6: write_block is high while a programming edge can be accepted (prog_n low, in_ready high, first_write_seen low, programming window not closed), and low otherwise, whatever the FIFO's own write enables are.
- R7: prog_n low is ignored while in_ready is low or after first_write_seen has gone high; the offsets keep their current values.
- R8: After the second programming edge, or after prog_n is released following the first, the window is closed: a third edge with prog_n low changes neither offset.
- R9: Offsets cover the full range 0..255: X = 255 puts the empty-side edge between counts 255 and 256, and Y = 255 puts the full-side edge between 256 and 257.
- R10: The flag is registered. It reflects a new word count on the first rising edge of clk_w after the count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_n | input | 1 | Offset programming strobe, active low |
| prog_data | input | 8 | Offset value (the low data-input bits) |
| in_ready | input | 1 | FIFO can accept a write |
| first_write_seen | input | 1 | A data word has been written since reset |
| word_count | input | 10 | Current number of stored words, 0..512 |
| level_flag | output | 1 | High when nearly empty or nearly full |
| write_block | output | 1 | Inhibits FIFO writes during programming |

## Verification
A table of word counts is applied with the default offsets. It probes each side of both thresholds (64/65 and 447/448) and both ends of the range, so an off-by-one or a swapped comparison shows up. Directed runs then program one, two and three edges with different values. Because the bench checks counts on each side of the empty and full edges separately, it can tell a write to X from a write to Y, and it catches a third edge that leaks through. Extreme offsets of 0 and 255 exercise the comparison width. Strobes given with input-ready low or after the first write must leave the default edges in place.

// File: rtl/lvlflag_pkg.sv
package lvlflag_pkg;

  typedef enum logic [1:0] {
    PG_OPEN   = 2'd0,
    PG_FIRST  = 2'd1,
    PG_LOCKED = 2'd2
  } prog_state_e;

  // Nearly-empty or nearly-full test on plain integers.
  function automatic logic near_bound(input int unsigned cnt,
                                      input int unsigned lo_ofs,
                                      input int unsigned hi_ofs,
                                      input int unsigned depth);
    logic lo_hit;
    logic hi_hit;
    lo_hit = (cnt <= lo_ofs);
    hi_hit = (cnt + hi_ofs >= depth);
    return lo_hit | hi_hit;
  endfunction

endpackage

// File: rtl/offset_prog.sv
module offset_prog
  import lvlflag_pkg::*;
#(
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic [OFS_W-1:0] prog_data,
  input  logic             in_ready,
  input  logic             first_write_seen,
  output logic [OFS_W-1:0] ofs_x,
  output logic [OFS_W-1:0] ofs_y,
  output logic             write_block
);

  localparam logic [OFS_W-1:0] DEF_VAL = OFS_W'(DEF_OFS);

  prog_state_e state_q, state_d;
  logic        window_open;
  logic        load_both;
  logic        load_y;

  assign window_open = (state_q != PG_LOCKED) && in_ready && !first_write_seen;
  assign write_block = window_open && !prog_n;
  assign load_both   = write_block && (state_q == PG_OPEN);
  assign load_y      = write_block && (state_q == PG_FIRST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PG_OPEN: begin
        if (first_write_seen) state_d = PG_LOCKED;
        else if (load_both)   state_d = PG_FIRST;
      end
      PG_FIRST:  state_d = PG_LOCKED;
      default:   state_d = PG_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_OPEN;
      ofs_x   <= DEF_VAL;
      ofs_y   <= DEF_VAL;
    end else begin
      state_q <= state_d;
      if (load_both) begin
        ofs_x <= prog_data;
        ofs_y <= prog_data;
      end else if (load_y) begin
        ofs_y <= prog_data;
      end
    end
  end

  // R8: once closed, offsets never move
  a_r8_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_LOCKED) |=> ($stable(ofs_x) && $stable(ofs_y)));

  // R5: the second edge leaves X alone
  a_r5_second_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_FIRST) |=> $stable(ofs_x));

  // R7: no load once a data word has gone in
  a_r7_no_load_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    first_write_seen |=> ($stable(ofs_x) && $stable(ofs_y)));

  // R4: the first accepted edge copies the value into both offsets
  a_r4_first_loads_both: assert property (@(posedge clk) disable iff (!rst_n)
    load_both |=> (ofs_x == $past(prog_data) && ofs_y == $past(prog_data)));

endmodule

// File: rtl/level_compare.sv
module level_compare
  import lvlflag_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OFS_W = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] word_count,
  input  logic [OFS_W-1:0] ofs_x,
  input  logic [OFS_W-1:0] ofs_y,
  output logic             flag_q
);

  logic flag_d;
  logic primed_q;

  assign flag_d = near_bound(int'(unsigned'(word_count)), int'(unsigned'(ofs_x)),
                             int'(unsigned'(ofs_y)), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b1;
      primed_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      primed_q <= 1'b1;
    end
  end

  // R2 / R10: low side seen one edge earlier forces the flag
  a_r2_empty_side: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && ($past(word_count) <= CNT_W'($past(ofs_x)))) |-> flag_q);

  // R2 / R10: strictly inside both margins the flag is low
  a_r2_mid_low: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && ($past(word_count) > CNT_W'($past(ofs_x)))
      && ((CNT_W + 1)'($past(word_count)) + (CNT_W + 1)'($past(ofs_y)) < (CNT_W + 1)'(DEPTH)))
    |-> !flag_q);

endmodule

// File: rtl/fifo_level_flag.sv
module fifo_level_flag
  import lvlflag_pkg::*;
#(
  parameter int DEPTH   = 512,
  parameter int OFS_W   = 8,
  parameter int DEF_OFS = 64,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_w,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic [OFS_W-1:0] prog_data,
  input  logic             in_ready,
  input  logic             first_write_seen,
  input  logic [CNT_W-1:0] word_count,
  output logic             level_flag,
  output logic             write_block
);

  logic [OFS_W-1:0] ofs_x;
  logic [OFS_W-1:0] ofs_y;

  offset_prog #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_prog (
    .clk              (clk_w),
    .rst_n            (rst_n),
    .prog_n           (prog_n),
    .prog_data        (prog_data),
    .in_ready         (in_ready),
    .first_write_seen (first_write_seen),
    .ofs_x            (ofs_x),
    .ofs_y            (ofs_y),
    .write_block      (write_block)
  );

  level_compare #(.DEPTH(DEPTH), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_cmp (
    .clk        (clk_w),
    .rst_n      (rst_n),
    .word_count (word_count),
    .ofs_x      (ofs_x),
    .ofs_y      (ofs_y),
    .flag_q     (level_flag)
  );

  // R6: inhibit only appears with an active strobe inside the window
  a_r6_block_needs_strobe: assert property (@(posedge clk_w) disable iff (!rst_n)
    write_block |-> (!prog_n && in_ready && !first_write_seen));

endmodule

// File: tb/fifo_level_flag_test.sv
`timescale 1ns/1ps
module fifo_level_flag_test;

  logic       clk_w = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_n = 1'b1;
  logic [7:0] prog_data = '0;
  logic       in_ready = 1'b0;
  logic       first_write_seen = 1'b0;
  logic [9:0] word_count = '0;
  logic       level_flag;
  logic       write_block;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_w = ~clk_w;

  fifo_level_flag uut (
    .clk_w(clk_w), .rst_n(rst_n), .prog_n(prog_n), .prog_data(prog_data),
    .in_ready(in_ready), .first_write_seen(first_write_seen),
    .word_count(word_count), .level_flag(level_flag), .write_block(write_block)
  );

  always @(posedge clk_w) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Independent model: low only when strictly between both margins.
  function automatic bit model_flag(int c, int x, int y);
    return !((c > x) && (512 - c > y));
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_w);
    rst_n = 1'b0; prog_n = 1'b1; in_ready = 1'b0; first_write_seen = 1'b0;
    word_count = 10'd0;
    repeat (4) @(negedge clk_w);
    rst_n = 1'b1;
    @(negedge clk_w);
    in_ready = 1'b1;
  endtask

  // Drive count at negedge, sample just after the capturing edge (R10).
  task automatic probe(input int c, input int x, input int y, input string tag);
    @(negedge clk_w);
    word_count = 10'(c);
    @(posedge clk_w);
    #1;
    check(level_flag, model_flag(c, x, y), tag);
  endtask

  task automatic prog_edges(input int n, input logic [7:0] v0, input logic [7:0] v1,
                            input logic [7:0] v2);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_w);
      prog_n = 1'b0;
      prog_data = (i == 0) ? v0 : (i == 1) ? v1 : v2;
    end
    @(negedge clk_w);
    prog_n = 1'b1;
  endtask

  // {count, expected flag} with default offsets
  localparam logic [10:0] VEC [10] = '{
    {10'd0, 1'b1}, {10'd1, 1'b1}, {10'd64, 1'b1}, {10'd65, 1'b0},
    {10'd200, 1'b0}, {10'd256, 1'b0}, {10'd447, 1'b0}, {10'd448, 1'b1},
    {10'd511, 1'b1}, {10'd512, 1'b1}
  };

  initial begin
    // R3: flag high during reset regardless of count
    word_count = 10'd200;
    repeat (3) @(negedge clk_w);
    check(level_flag, 1'b1, "R3 during reset");
    do_reset();
    check(level_flag, 1'b1, "R3 after release");

    // R1 / R2 / R10: default table
    for (int i = 0; i < 10; i++)
      probe(int'(VEC[i][10:1]), 64, 64, "R1 default table");
    check(VEC[3][0], model_flag(65, 64, 64), "R2 model agrees with table");

    // R10: one edge of latency
    @(negedge clk_w); word_count = 10'd100;
    @(posedge clk_w); #1;
    @(negedge clk_w); word_count = 10'd10;
    #1; check(level_flag, 1'b0, "R10 not yet updated");
    @(posedge clk_w); #1;
    check(level_flag, 1'b1, "R10 updated after edge");

    // R4 / R6: single edge loads both
    do_reset();
    @(negedge clk_w); prog_n = 1'b0; prog_data = 8'd32; #1;
    check(write_block, 1'b1, "R6 inhibit while programming");
    @(negedge clk_w); prog_n = 1'b1; #1;
    check(write_block, 1'b0, "R6 inhibit released");
    probe(32, 32, 32, "R4 X edge high");
    probe(33, 32, 32, "R4 X edge low");
    probe(479, 32, 32, "R4 Y edge low");
    probe(480, 32, 32, "R4 Y edge high");
    @(negedge clk_w); prog_n = 1'b0; prog_data = 8'd1; #1;
    check(write_block, 1'b0, "R8 no inhibit when closed");
    @(negedge clk_w); prog_n = 1'b1;
    probe(33, 32, 32, "R8 release-closed X kept");

    // R5: two edges
    do_reset();
    prog_edges(2, 8'd100, 8'd5, 8'd0);
    probe(100, 100, 5, "R5 X kept high");
    probe(101, 100, 5, "R5 X kept low");
    probe(506, 100, 5, "R5 Y reloaded low");
    probe(507, 100, 5, "R5 Y reloaded high");

    // R8: three edges, third ignored
    do_reset();
    prog_edges(3, 8'd10, 8'd20, 8'd30);
    probe(11, 10, 20, "R8 X not third");
    probe(482, 10, 20, "R8 Y not third");
    probe(492, 10, 20, "R8 Y second value");

    // R7: strobe with in_ready low
    do_reset();
    @(negedge clk_w); in_ready = 1'b0; prog_n = 1'b0; prog_data = 8'd5; #1;
    check(write_block, 1'b0, "R7 no inhibit without ready");
    @(negedge clk_w); prog_n = 1'b1; in_ready = 1'b1;
    probe(64, 64, 64, "R7 ready low ignored high");
    probe(65, 64, 64, "R7 ready low ignored low");

    // R7: strobe after first write
    do_reset();
    @(negedge clk_w); first_write_seen = 1'b1;
    @(negedge clk_w); prog_n = 1'b0; prog_data = 8'd200; #1;
    check(write_block, 1'b0, "R7 no inhibit after write");
    @(negedge clk_w); prog_n = 1'b1;
    probe(65, 64, 64, "R7 after write ignored");

    // R9: extremes
    do_reset();
    prog_edges(1, 8'd255, 8'd0, 8'd0);
    probe(255, 255, 255, "R9 X=255 high");
    probe(256, 255, 255, "R9 256 low");
    probe(257, 255, 255, "R9 Y=255 high");
    do_reset();
    prog_edges(2, 8'd0, 8'd0, 8'd0);
    probe(0, 0, 0, "R9 X=0 high");
    probe(1, 0, 0, "R9 X=0 low");
    probe(511, 0, 0, "R9 Y=0 low");
    probe(512, 0, 0, "R9 Y=0 high");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule